// File: doc/BRIEF.md
# Vertical-Blank NMI Flag and Trigger

This block produces the vertical-blank non-maskable interrupt for a video-synchronised CPU and keeps the read-to-clear vertical-blank status bit that software polls. It watches the current scanline and the master-cycle position within that line, together with an overscan selector that moves the start of blanking later in the frame.

When the CPU reads the status register, the block returns the bit that read sees and updates its record of whether the flag has been consumed this frame. At every instruction boundary the CPU core reports, the block decides whether the NMI is taken there. If an IRQ is due at the same boundary, the block lets it through only when no NMI is taken.

The CPU core, the other status bits and the bus decode are outside the block. Outputs are combinational from the inputs and two flops of frame state. That state updates on the clock edge that ends the cycle of the read or the boundary.

Top module: `vblnmi_ctrl`

## Requirements
- R1: Blanking starts on line 225 when `overscan` is 0 and on line 240 when `overscan` is 1.
- R2: A read samples `rd_pos + 2` master cycles into the line. It returns `rd_data`=1 if that sample is at least cycle 2 of the start line, or if the line is past the start line, provided no earlier read this frame consumed the flag.
- R3: A read on any line before the start line returns 0.
- R4: A read that returns 1 marks the flag consumed. Later reads return 0 until the next frame.
- R5: A read whose sample lands exactly on cycle 2 of the start line (`rd_pos`=0) returns 1 but does not consume the flag, so the next read also returns 1.
- R6: Any cycle with `line`=0 starts a new frame. It clears the consumed marker and re-arms the NMI.
- R7: At a boundary (`boundary`=1), the NMI window is open when the line equals the start line and `mcycle` is at least 6 + `last_len`, or when the line is past the start line.
- R8: `nmi_take` is 1 only while `nmi_en` is 1, and at most once per frame.
- R9: `irq_take` is 1 exactly when `boundary` and `irq_due` are both 1 and `nmi_take` is 0.
- R10: `rd_data` is 0 in any cycle where `rd_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line | input | 9 | Current scanline |
| mcycle | input | 11 | Master cycle within the line |
| overscan | input | 1 | 1 selects the later blanking start line |
| nmi_en | input | 1 | Enables the NMI |
| rd_stb | input | 1 | Status register read in this cycle |
| rd_pos | input | 11 | Master cycle at which the read's bus access begins |
| rd_data | output | 1 | Status bit value returned to the read |
| boundary | input | 1 | Instruction boundary in this cycle |
| last_len | input | 4 | Master-cycle length of the last cycle of the finishing instruction |
| irq_due | input | 1 | Maskable interrupt is pending |
| nmi_take | output | 1 | NMI taken at this boundary |
| irq_take | output | 1 | IRQ taken at this boundary |

## Verification
The hardest case to reach is the one-cycle exception: the sample must fall exactly on cycle 2 of the start line. Only a read whose access begins at cycle 0 of that line produces it. The bench places two such reads back to back on both start lines and confirms that both return 1. It then shows that a read one cycle later consumes the flag. NMI thresholds are approached one cycle below and at the exact limit, for both last-cycle lengths.

// File: rtl/vblnmi_pkg.sv
package vblnmi_pkg;
   typedef struct packed {
      logic flag_win;
      logic first_cyc;
      logic nmi_win;
      logic frame_start;
   } vbl_win_t;
endpackage

// File: rtl/vblnmi_window.sv
module vblnmi_window
   import vblnmi_pkg::*;
#(
   parameter int LINE_W    = 9,
   parameter int CYC_W     = 11,
   parameter int LEN_W     = 4,
   parameter int STD_LINE  = 225,
   parameter int OS_LINE   = 240,
   parameter int SAMPLE_OFS = 2,
   parameter int FLAG_CYC  = 2,
   parameter int NMI_BASE  = 6
) (
   input  logic [LINE_W-1:0] line,
   input  logic [CYC_W-1:0]  mcycle,
   input  logic              overscan,
   input  logic [CYC_W-1:0]  rd_pos,
   input  logic [LEN_W-1:0]  last_len,
   output vbl_win_t          win
);
   localparam int SW = CYC_W + 1;
   localparam logic [LINE_W-1:0] STD_L = LINE_W'(STD_LINE);
   localparam logic [LINE_W-1:0] OS_L  = LINE_W'(OS_LINE);

   logic [LINE_W-1:0] start_l;
   logic [SW-1:0]     sample;
   logic [SW-1:0]     nmi_thr;
   logic              on_start, past_start;

   assign start_l    = overscan ? OS_L : STD_L;
   assign on_start   = (line == start_l);
   assign past_start = (line > start_l);
   assign sample     = SW'(rd_pos) + SW'(SAMPLE_OFS);
   assign nmi_thr    = SW'(NMI_BASE) + SW'(last_len);

   always_comb begin
      win.flag_win    = (on_start && (sample >= SW'(FLAG_CYC))) || past_start;
      win.first_cyc   = on_start && (sample == SW'(FLAG_CYC));
      win.nmi_win     = (on_start && (SW'(mcycle) >= nmi_thr)) || past_start;
      win.frame_start = (line == '0);
   end
endmodule

// File: rtl/vblnmi_status.sv
module vblnmi_status
   import vblnmi_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  vbl_win_t win,
   input  logic     rd_stb,
   output logic     rd_data
);
   logic consumed;

   assign rd_data = rd_stb && win.flag_win && !consumed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         consumed <= 1'b0;
      else if (win.frame_start)
         consumed <= 1'b0;
      else if (rd_data && !win.first_cyc)
         consumed <= 1'b1;
   end
endmodule

// File: rtl/vblnmi_gate.sv
module vblnmi_gate
   import vblnmi_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  vbl_win_t win,
   input  logic     nmi_en,
   input  logic     boundary,
   input  logic     irq_due,
   output logic     nmi_take,
   output logic     irq_take
);
   logic fired;

   assign nmi_take = boundary && nmi_en && win.nmi_win && !fired;
   assign irq_take = boundary && irq_due && !nmi_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fired <= 1'b0;
      else if (win.frame_start)
         fired <= 1'b0;
      else if (nmi_take)
         fired <= 1'b1;
   end
endmodule

// File: rtl/vblnmi_ctrl.sv
module vblnmi_ctrl
   import vblnmi_pkg::*;
#(
   parameter int LINE_W     = 9,
   parameter int CYC_W      = 11,
   parameter int LEN_W      = 4,
   parameter int STD_LINE   = 225,
   parameter int OS_LINE    = 240,
   parameter int SAMPLE_OFS = 2,
   parameter int FLAG_CYC   = 2,
   parameter int NMI_BASE   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line,
   input  logic [CYC_W-1:0]  mcycle,
   input  logic              overscan,
   input  logic              nmi_en,
   input  logic              rd_stb,
   input  logic [CYC_W-1:0]  rd_pos,
   output logic              rd_data,
   input  logic              boundary,
   input  logic [LEN_W-1:0]  last_len,
   input  logic              irq_due,
   output logic              nmi_take,
   output logic              irq_take
);
   localparam int MAX_LINE = (1 << LINE_W) - 1;

   generate
      if (STD_LINE < 1 || STD_LINE > MAX_LINE || OS_LINE > MAX_LINE) begin : g_bad_line
         $error("vblnmi_ctrl: start lines must fit in LINE_W and be above 0");
      end
      if (OS_LINE < STD_LINE) begin : g_bad_order
         $error("vblnmi_ctrl: overscan start line must not precede the normal one");
      end
      if (SAMPLE_OFS > FLAG_CYC) begin : g_bad_ofs
         $error("vblnmi_ctrl: sample offset beyond flag cycle hides the first-cycle case");
      end
   endgenerate

   vbl_win_t win;

   vblnmi_window #(
      .LINE_W(LINE_W), .CYC_W(CYC_W), .LEN_W(LEN_W),
      .STD_LINE(STD_LINE), .OS_LINE(OS_LINE),
      .SAMPLE_OFS(SAMPLE_OFS), .FLAG_CYC(FLAG_CYC), .NMI_BASE(NMI_BASE)
   ) u_window (
      .line(line), .mcycle(mcycle), .overscan(overscan),
      .rd_pos(rd_pos), .last_len(last_len), .win(win)
   );

   vblnmi_status u_status (
      .clk(clk), .rst_n(rst_n), .win(win),
      .rd_stb(rd_stb), .rd_data(rd_data)
   );

   vblnmi_gate u_gate (
      .clk(clk), .rst_n(rst_n), .win(win), .nmi_en(nmi_en),
      .boundary(boundary), .irq_due(irq_due),
      .nmi_take(nmi_take), .irq_take(irq_take)
   );
endmodule

// File: rtl/vblnmi_ctrl_chk.sv
module vblnmi_ctrl_chk #(
   parameter int LINE_W   = 9,
   parameter int CYC_W    = 11,
   parameter int STD_LINE = 225,
   parameter int OS_LINE  = 240
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LINE_W-1:0] line,
   input logic              overscan,
   input logic              nmi_en,
   input logic              rd_stb,
   input logic [CYC_W-1:0]  rd_pos,
   input logic              rd_data,
   input logic              boundary,
   input logic              irq_due,
   input logic              nmi_take,
   input logic              irq_take
);
   logic [LINE_W-1:0] exp_start;
   logic              seen_nmi, seen_use;

   assign exp_start = overscan ? LINE_W'(OS_LINE) : LINE_W'(STD_LINE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_nmi <= 1'b0;
         seen_use <= 1'b0;
      end else if (line == '0) begin
         seen_nmi <= 1'b0;
         seen_use <= 1'b0;
      end else begin
         if (nmi_take) seen_nmi <= 1'b1;
         if (rd_data && !(line == exp_start && rd_pos == '0)) seen_use <= 1'b1;
      end
   end

   assert_no_early_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data |-> (line >= exp_start));
   assert_used_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && seen_use && line != '0) |-> !rd_data);
   assert_nmi_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_take |-> (nmi_en && boundary));
   assert_nmi_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_take && line != '0) |-> !seen_nmi);
   assert_nmi_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_take && irq_take));
   assert_irq_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && irq_due && !nmi_take) |-> irq_take);
   assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> !rd_data);
endmodule

bind vblnmi_ctrl vblnmi_ctrl_chk #(
   .LINE_W(LINE_W), .CYC_W(CYC_W), .STD_LINE(STD_LINE), .OS_LINE(OS_LINE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line(line), .overscan(overscan),
   .nmi_en(nmi_en), .rd_stb(rd_stb), .rd_pos(rd_pos), .rd_data(rd_data),
   .boundary(boundary), .irq_due(irq_due),
   .nmi_take(nmi_take), .irq_take(irq_take)
);

// File: tb/vblnmi_ctrl_test.sv
module vblnmi_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  line = '0;
   logic [10:0] mcycle = '0;
   logic        overscan = 1'b0;
   logic        nmi_en = 1'b0;
   logic        rd_stb = 1'b0;
   logic [10:0] rd_pos = '0;
   logic        rd_data;
   logic        boundary = 1'b0;
   logic [3:0]  last_len = 4'd6;
   logic        irq_due = 1'b0;
   logic        nmi_take, irq_take;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vblnmi_ctrl uut (
      .clk(clk), .rst_n(rst_n), .line(line), .mcycle(mcycle),
      .overscan(overscan), .nmi_en(nmi_en), .rd_stb(rd_stb), .rd_pos(rd_pos),
      .rd_data(rd_data), .boundary(boundary), .last_len(last_len),
      .irq_due(irq_due), .nmi_take(nmi_take), .irq_take(irq_take)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic idle();
      rd_stb = 1'b0; boundary = 1'b0; irq_due = 1'b0;
   endtask

   task automatic new_frame();
      @(negedge clk); idle(); line = '0;
      @(negedge clk);
   endtask

   task automatic do_read(input int ln, input int pos, input logic exp, input string req);
      idle(); line = 9'(ln); rd_pos = 11'(pos); rd_stb = 1'b1;
      #2 check(req, rd_data, exp);
      @(negedge clk); idle();
   endtask

   task automatic do_bound(input int ln, input int cyc, input int len, input logic irq,
                           input logic exp_nmi, input logic exp_irq, input string req);
      idle(); line = 9'(ln); mcycle = 11'(cyc); last_len = 4'(len);
      irq_due = irq; boundary = 1'b1;
      #2 check(req, nmi_take, exp_nmi);
      check(req, irq_take, exp_irq);
      @(negedge clk); idle();
   endtask

   task automatic t_reset();
      #2 check("R10 reset", rd_data, 1'b0);
      check("R8 reset", nmi_take, 1'b0);
      @(negedge clk); rst_n = 1'b1; @(negedge clk);
   endtask

   task automatic t_before_start();
      overscan = 1'b0; new_frame();
      do_read(100, 50, 1'b0, "R3 line 100");
      do_read(224, 1300, 1'b0, "R3 line 224");
      overscan = 1'b1;
      do_read(230, 10, 1'b0, "R1 overscan line 230");
      overscan = 1'b0;
      do_read(230, 10, 1'b1, "R1 normal line 230");
   endtask

   task automatic t_consume();
      overscan = 1'b0; new_frame();
      do_read(226, 40, 1'b1, "R2 past start");
      do_read(226, 80, 1'b0, "R4 second read");
      do_read(250, 0, 1'b0, "R4 later line");
      new_frame();
      do_read(226, 40, 1'b1, "R6 rearmed");
      rd_stb = 1'b0; line = 9'd240;
      #2 check("R10 no strobe", rd_data, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_first_cycle();
      overscan = 1'b0; new_frame();
      do_read(225, 0, 1'b1, "R5 first read");
      do_read(225, 0, 1'b1, "R5 repeat read");
      do_read(225, 1, 1'b1, "R2 start line cycle 3");
      do_read(225, 6, 1'b0, "R4 after consume");
      overscan = 1'b1; new_frame();
      do_read(239, 0, 1'b0, "R1 overscan line 239");
      do_read(240, 0, 1'b1, "R5 overscan first");
      do_read(240, 0, 1'b1, "R5 overscan repeat");
      overscan = 1'b0;
   endtask

   task automatic t_nmi();
      nmi_en = 1'b1; new_frame();
      do_bound(225, 11, 6, 1'b0, 1'b0, 1'b0, "R7 below 12");
      do_bound(225, 12, 6, 1'b0, 1'b1, 1'b0, "R7 at 12");
      do_bound(226, 5, 6, 1'b0, 1'b0, 1'b0, "R8 once");
      new_frame();
      do_bound(225, 13, 8, 1'b0, 1'b0, 1'b0, "R7 below 14");
      do_bound(225, 14, 8, 1'b0, 1'b1, 1'b0, "R7 at 14");
      new_frame();
      do_bound(224, 1300, 6, 1'b0, 1'b0, 1'b0, "R7 line before");
      do_bound(226, 0, 6, 1'b0, 1'b1, 1'b0, "R7 past start");
   endtask

   task automatic t_enable();
      new_frame(); nmi_en = 1'b0;
      do_bound(230, 0, 6, 1'b0, 1'b0, 1'b0, "R8 disabled");
      nmi_en = 1'b1;
      do_bound(231, 0, 6, 1'b0, 1'b1, 1'b0, "R8 enabled late");
   endtask

   task automatic t_priority();
      nmi_en = 1'b1; new_frame();
      do_bound(100, 0, 6, 1'b1, 1'b0, 1'b1, "R9 irq alone");
      do_bound(230, 0, 6, 1'b1, 1'b1, 1'b0, "R9 nmi wins");
      do_bound(231, 0, 6, 1'b1, 1'b0, 1'b1, "R9 irq after nmi");
      idle(); line = 9'd232; irq_due = 1'b1;
      #2 check("R9 no boundary", irq_take, 1'b0);
      @(negedge clk); idle();
   endtask

   initial begin
      #100000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_before_start();
      t_consume();
      t_first_cycle();
      t_nmi();
      t_enable();
      t_priority();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule